// File: doc/BRIEF.md
# SPI Slave Register File

This block is a serial-peripheral slave that gives an external SPI master access to a small bank of byte registers inside a chip. The serial clock, slave select and data input are brought into the core clock through synchronizers, and every shift decision is taken on a detected edge of the synchronized clock. Each time the slave is selected, the first byte received is a command. Its two top bits choose the operation and its six low bits give a starting register address. The bytes that follow are either written into registers or answered with register contents on the data output. The address advances by one after every data byte, so a single frame can cover a run of registers.

The register space holds a configuration byte, a status byte, an eight-byte read-only return area and up to sixteen user bytes. The core fills the return area through a load strobe, which also raises a ready flag. Configuration selects the clock polarity and phase, bit order, user-register access, interrupt enable and a disable bit, and can be rewritten over the serial link at any time. The interrupt output tells the core side that return data is waiting. Remote-forwarding commands are recognised and discarded.

Top module: `spi_slave_regfile`

## Requirements
- R1: After reset the configuration byte, the status flag, all user bytes, the interrupt and the data output are 0.
- R2: Each low period of the select line begins with a command byte whose bits [7:6] choose the operation (00 write, 10 read, 11 remote, 01 reserved) and whose bits [5:0] give the start address. Raising select returns the slave to idle and drops any partial byte, so the next low period starts with a fresh command.
- R3: In a write frame, each following byte is stored at the current address, and the address then advances by one. The configuration byte at address 0x00 takes all eight bits.
- R4: In a read frame, during each following byte the data output shifts out the register at the current address, and the address then advances by one (wrapping from 0x3F to 0x00). Unmapped addresses read as 0.
- R5: The data output is 0 whenever select is high and whenever the slave is not in the data byte of a read frame.
- R6: Configuration bit 2 (clock idle level) and bit 3 (phase) decide the sampling edge. Input data is sampled on the rising clock edge when the two bits are equal and on the falling edge otherwise, and output data changes just after each sampling edge. A frame that changes either bit ends after that byte.
- R7: Configuration bit 4 set sends and receives bit 0 first; clear sends bit 7 first. A new value written inside a frame applies from the next byte of that frame.
- R8: After a remote (11) or reserved (01) command, the rest of the frame changes no register and the data output stays 0.
- R9: Addresses 0x08 to 0x0F are a read-only return area. Byte k holds ret_data[8k+7:8k] as captured on a ret_load pulse, and serial writes to these addresses are ignored.
- R10: Status bit 0 (address 0x01) is set by ret_load and cleared by a serial write of a byte with bit 0 set. A load in the same cycle wins, and the other status bits read 0.
- R11: User bytes at 0x20 to 0x2F can be written only while configuration bit 5 is set, and read as 0 while it is clear. User byte i appears on user_regs[8i+7:8i].
- R12: irq is high exactly when configuration bit 1 and status bit 0 are both set.
- R13: While configuration bit 0 is set, only writes to address 0x00 take effect, and read commands are discarded with the data output held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not driving read data |
| ret_load | input | 1 | Pulse that captures ret_data and sets the ready flag |
| ret_data | input | RET_BYTES*8 | Return data for the read-only area |
| cfg_out | output | 8 | Current configuration byte |
| user_regs | output | NUM_USER*8 | All user bytes, byte i at bits [8i+7:8i] |
| irq | output | 1 | Return-data interrupt |

## Verification
The hardest case to reach from the pins is a bit-order change partway through a frame. The configuration write has to land at the end of one byte, and the very next byte of the same frame must already be decoded in the new order. The bench gets there by first loading return data, so that the ready flag is set. It then sends a write burst that starts at address 0x00 and writes a configuration byte with bit 4 set, followed by a status byte of 0x01 sent least-significant bit first. Only a slave that switched order at the byte boundary clears the flag and drops the interrupt. A frame cut off in the middle of a data byte, followed by a new frame, shows that deselection clears the bit counter.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int ADDR_W = 6;

    // Frame-level states of the serial engine
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,   // select high
        ST_CMD     = 3'd1,   // receiving the command byte
        ST_WRITE   = 3'd2,   // data bytes go into registers
        ST_READ    = 3'd3,   // data bytes come out of registers
        ST_DISCARD = 3'd4    // remote / reserved / refused: ignore the rest
    } frame_state_e;

    // Command operation field, command bits [7:6]
    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_RSVD   = 2'b01,
        OP_READ   = 2'b10,
        OP_REMOTE = 2'b11
    } cmd_op_e;

    localparam logic [ADDR_W-1:0] A_CFG  = 6'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h01;
    localparam logic [ADDR_W-1:0] A_RET  = 6'h08;
    localparam logic [ADDR_W-1:0] A_USER = 6'h20;

    localparam int CFG_OFF  = 0;
    localparam int CFG_IRQ  = 1;
    localparam int CFG_CPOL = 2;
    localparam int CFG_CPHA = 3;
    localparam int CFG_LSB  = 4;
    localparam int CFG_USER = 5;

    // Shift one received bit into a partial byte in the chosen order
    function automatic logic [7:0] shift_in(input logic [7:0] sofar,
                                            input logic       bit_v,
                                            input logic       lsb_first);
        return lsb_first ? {bit_v, sofar[7:1]} : {sofar[6:0], bit_v};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Brings the serial pins into the core clock and finds clock edges.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic ss_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ss_active,
    output logic mosi_s
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] ss_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            ss_pipe   <= '1;
            mosi_pipe <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[TOP-1:0], sclk_in};
            ss_pipe   <= {ss_pipe[TOP-1:0], ss_n_in};
            mosi_pipe <= {mosi_pipe[TOP-1:0], mosi_in};
            sclk_last <= sclk_pipe[TOP];
        end
    end

    assign sclk_rise = sclk_pipe[TOP] & ~sclk_last;
    assign sclk_fall = ~sclk_pipe[TOP] & sclk_last;
    assign ss_active = ~ss_pipe[TOP];
    assign mosi_s    = mosi_pipe[TOP];

endmodule

// File: rtl/spi_frame_fsm.sv
// Command decode, bit counting, address stepping and output bit choice.
module spi_frame_fsm
    import spi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_active,
    input  logic              sample_edge,
    input  logic              mosi_bit,
    input  logic              lsb_first,
    input  logic              slave_off,
    input  logic [7:0]        rd_data,
    output frame_state_e      state_o,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso_bit
);

    frame_state_e      state_q, state_d;
    logic [2:0]        bit_cnt_q;
    logic [7:0]        shift_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        tx_q;
    logic [7:0]        rx_byte;
    logic              byte_done;
    cmd_op_e           cmd_op;

    assign rx_byte   = shift_in(shift_q, mosi_bit, lsb_first);
    assign byte_done = ss_active && sample_edge && (bit_cnt_q == 3'd7);
    assign cmd_op    = cmd_op_e'(rx_byte[7:6]);

    // Transitions: IDLE->CMD on select; CMD->WRITE/READ/DISCARD on
    // the eighth bit; any state->IDLE when select goes high.
    always_comb begin
        state_d = state_q;
        if (!ss_active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        if (cmd_op == OP_WRITE)
                            state_d = ST_WRITE;
                        else if (cmd_op == OP_READ && !slave_off)
                            state_d = ST_READ;
                        else
                            state_d = ST_DISCARD;
                    end
                end
                ST_WRITE, ST_READ, ST_DISCARD: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter, partial byte, address and outgoing byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            addr_q    <= '0;
            tx_q      <= '0;
        end else if (!ss_active) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            addr_q    <= '0;
            tx_q      <= '0;
        end else if (sample_edge) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            shift_q   <= rx_byte;
            if (bit_cnt_q == 3'd7) begin
                unique case (state_q)
                    ST_CMD: begin
                        addr_q <= rx_byte[ADDR_W-1:0];
                        tx_q   <= rd_data;
                    end
                    ST_WRITE: addr_q <= addr_q + ADDR_W'(1);
                    ST_READ: begin
                        addr_q <= addr_q + ADDR_W'(1);
                        tx_q   <= rd_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        state_o  = state_q;
        wr_en    = byte_done && (state_q == ST_WRITE);
        wr_addr  = addr_q;
        wr_data  = rx_byte;
        rd_addr  = (state_q == ST_CMD) ? rx_byte[ADDR_W-1:0] : addr_q + ADDR_W'(1);
        miso_bit = 1'b0;
        if (state_q == ST_READ)
            miso_bit = lsb_first ? tx_q[bit_cnt_q] : tx_q[3'd7 - bit_cnt_q];
    end

endmodule

// File: rtl/spi_slave_regs.sv
// Configuration, status, return area and user bytes.
// RET_BYTES in 2..8 and NUM_USER in 2..16 keep the map inside its windows.
module spi_slave_regs
    import spi_slv_pkg::*;
#(
    parameter int NUM_USER  = 16,
    parameter int RET_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  ret_load,
    input  logic [RET_BYTES*8-1:0] ret_data,
    output logic [7:0]            cfg_o,
    output logic                  ready_o,
    output logic [NUM_USER*8-1:0] user_o
);

    localparam int RET_IDX_W  = $clog2(RET_BYTES);
    localparam int USER_IDX_W = $clog2(NUM_USER);
    localparam logic [ADDR_W-1:0] RET_END  = A_RET + ADDR_W'(RET_BYTES);
    localparam logic [ADDR_W-1:0] USER_END = A_USER + ADDR_W'(NUM_USER);

    logic [7:0] cfg_q;
    logic       ready_q;
    logic [7:0] ret_q  [RET_BYTES];
    logic [7:0] user_q [NUM_USER];
    logic       write_ok;

    // While disabled only the configuration byte accepts writes
    assign write_ok = wr_en && (!cfg_q[CFG_OFF] || wr_addr == A_CFG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            if (write_ok && wr_addr == A_CFG)
                cfg_q <= wr_data;
            if (ret_load)
                ready_q <= 1'b1;
            else if (write_ok && wr_addr == A_STAT && wr_data[0])
                ready_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < RET_BYTES; k++) begin : g_ret
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ret_q[k] <= '0;
            else if (ret_load) ret_q[k] <= ret_data[8*k +: 8];
        end
    end

    for (genvar i = 0; i < NUM_USER; i++) begin : g_user
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                user_q[i] <= '0;
            else if (write_ok && cfg_q[CFG_USER] && wr_addr == A_USER + ADDR_W'(i))
                user_q[i] <= wr_data;
        end
        assign user_o[8*i +: 8] = user_q[i];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CFG)
            rd_data = cfg_q;
        else if (rd_addr == A_STAT)
            rd_data = {7'b0, ready_q};
        else if (rd_addr >= A_RET && rd_addr < RET_END)
            rd_data = ret_q[rd_addr[RET_IDX_W-1:0]];
        else if (rd_addr >= A_USER && rd_addr < USER_END && cfg_q[CFG_USER])
            rd_data = user_q[rd_addr[USER_IDX_W-1:0]];
    end

    assign cfg_o   = cfg_q;
    assign ready_o = ready_q;

endmodule

// File: rtl/spi_slave_regfile.sv
module spi_slave_regfile
    import spi_slv_pkg::*;
#(
    parameter int NUM_USER    = 16,
    parameter int RET_BYTES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sclk,
    input  logic                   spi_ss_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    input  logic                   ret_load,
    input  logic [RET_BYTES*8-1:0] ret_data,
    output logic [7:0]             cfg_out,
    output logic [NUM_USER*8-1:0]  user_regs,
    output logic                   irq
);

    logic              sclk_rise, sclk_fall, ss_active, mosi_s;
    logic              sample_edge;
    logic [7:0]        cfg_w;
    logic              ready;
    frame_state_e      fsm_state;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0]        wr_data, rd_data;
    logic              miso_bit;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .ss_n_in   (spi_ss_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .ss_active (ss_active),
        .mosi_s    (mosi_s)
    );

    // Equal polarity and phase bits sample on the rising edge
    assign sample_edge = (cfg_w[CFG_CPOL] == cfg_w[CFG_CPHA]) ? sclk_rise : sclk_fall;

    spi_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_active   (ss_active),
        .sample_edge (sample_edge),
        .mosi_bit    (mosi_s),
        .lsb_first   (cfg_w[CFG_LSB]),
        .slave_off   (cfg_w[CFG_OFF]),
        .rd_data     (rd_data),
        .state_o     (fsm_state),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .miso_bit    (miso_bit)
    );

    spi_slave_regs #(.NUM_USER(NUM_USER), .RET_BYTES(RET_BYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ret_load (ret_load),
        .ret_data (ret_data),
        .cfg_o    (cfg_w),
        .ready_o  (ready),
        .user_o   (user_regs)
    );

    assign cfg_out  = cfg_w;
    assign irq      = cfg_w[CFG_IRQ] & ready;
    assign spi_miso = ~spi_ss_n & miso_bit;

endmodule

// File: rtl/spi_slave_regfile_chk.sv
module spi_slave_regfile_chk
    import spi_slv_pkg::*;
#(
    parameter int NUM_USER = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ss_active,
    input frame_state_e          state,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [7:0]            cfg_out,
    input logic [NUM_USER*8-1:0] user_regs,
    input logic                  ret_load,
    input logic                  ready,
    input logic                  irq,
    input logic                  spi_miso
);

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_active |=> state == ST_IDLE); // R2

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CFG) |=> $stable(cfg_out)); // R3

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_READ |-> !spi_miso); // R5

    AST_DISCARD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DISCARD |-> !wr_en); // R8

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_load |=> ready); // R10

    AST_USER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_out[CFG_USER] |=> $stable(user_regs)); // R11

    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !irq); // R12

    AST_OFF_USER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out[CFG_OFF] && !(wr_en && wr_addr == A_CFG)) |=> $stable(user_regs)); // R13

endmodule

bind spi_slave_regfile spi_slave_regfile_chk #(.NUM_USER(NUM_USER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_active (ss_active),
    .state     (fsm_state),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cfg_out   (cfg_w),
    .user_regs (user_regs),
    .ret_load  (ret_load),
    .ready     (ready),
    .irq       (irq),
    .spi_miso  (spi_miso)
);

// File: tb/tb_spi_slave_regfile.sv
module tb_spi_slave_regfile;

    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sclk, ss_n, mosi;
    logic         miso;
    logic         ret_load;
    logic [63:0]  ret_data;
    logic [7:0]   cfg_out;
    logic [127:0] user_regs;
    logic         irq;

    always #10 clk = ~clk;   // 50 MHz

    spi_slave_regfile dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_ss_n(ss_n),
        .spi_mosi(mosi), .spi_miso(miso), .ret_load(ret_load),
        .ret_data(ret_data), .cfg_out(cfg_out), .user_regs(user_regs), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0] m_cfg;
    logic       m_ready;
    logic [7:0] m_ret  [8];
    logic [7:0] m_user [16];

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 0;
    logic [7:0] txq [$];

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [5:0] a);
        if (a == 6'h00) return m_cfg;
        if (a == 6'h01) return {7'b0, m_ready};
        if (a >= 6'h08 && a < 6'h10) return m_ret[a[2:0]];
        if (a >= 6'h20 && a < 6'h30) return m_cfg[5] ? m_user[a[3:0]] : 8'h00;
        return 8'h00;
    endfunction

    task automatic m_write(input logic [5:0] a, input logic [7:0] d);
        if (m_cfg[0] && a != 6'h00) return;
        if (a == 6'h00) m_cfg = d;
        else if (a == 6'h01) begin if (d[0]) m_ready = 1'b0; end
        else if (a >= 6'h20 && a < 6'h30 && m_cfg[5]) m_user[a[3:0]] = d;
    endtask

    function automatic logic [127:0] m_user_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[8*i +: 8] = m_user[i];
        return f;
    endfunction

    // One byte (or fewer bits) as the master, in the model's current mode
    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        logic cpol, cpha, lsb;
        cpol = m_cfg[2]; cpha = m_cfg[3]; lsb = m_cfg[4];
        rx = 8'h00;
        for (int k = 0; k < nbits; k++) begin
            int idx;
            idx = lsb ? k : 7 - k;
            if (!cpha) begin
                @(negedge clk) mosi = tx[idx];
                repeat (HALF) @(negedge clk);
                rx[idx] = miso;
                sclk = ~cpol;
                repeat (HALF) @(negedge clk);
                sclk = cpol;
            end else begin
                @(negedge clk) begin sclk = ~cpol; mosi = tx[idx]; end
                repeat (HALF) @(negedge clk);
                rx[idx] = miso;
                sclk = cpol;
                repeat (HALF) @(negedge clk);
            end
        end
    endtask

    task automatic open_frame();
        @(negedge clk) sclk = m_cfg[2];
        repeat (4) @(negedge clk);
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame(input string req);
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        check(req, "cfg_out", 128'(cfg_out), 128'(m_cfg));
        check(req, "user_regs", user_regs, m_user_flat());
        check("R12", "irq", 128'(irq), 128'(m_cfg[1] & m_ready));
    endtask

    // Sends txq as one frame and checks every returned byte
    task automatic run_frame(input string req);
        logic [7:0] rx;
        logic [5:0] addr;
        int mode;
        open_frame();
        xfer_bits(txq[0], 8, rx);
        check(req, "miso during command", 128'(rx), 128'(0));
        addr = txq[0][5:0];
        if (txq[0][7:6] == 2'b00) mode = 1;
        else if (txq[0][7:6] == 2'b10 && !m_cfg[0]) mode = 2;
        else mode = 0;
        for (int i = 1; i < txq.size(); i++) begin
            logic [7:0] exp;
            exp = (mode == 2) ? m_read(addr) : 8'h00;
            xfer_bits(txq[i], 8, rx);
            check(req, "miso data byte", 128'(rx), 128'(exp));
            if (mode == 1) m_write(addr, txq[i]);
            addr = addr + 6'd1;
        end
        close_frame(req);
        txq.delete();
    endtask

    task automatic load_ret(input logic [63:0] d);
        @(negedge clk) begin ret_load = 1'b1; ret_data = d; end
        @(negedge clk) ret_load = 1'b0;
        for (int k = 0; k < 8; k++) m_ret[k] = d[8*k +: 8];
        m_ready = 1'b1;
        @(negedge clk);
        check("R12", "irq after load", 128'(irq), 128'(m_cfg[1]));
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Every clock: output quiet while deselected (R5)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ss_n === 1'b1 && !done) begin
            vectors++;
            if (miso !== 1'b0) begin
                fails++;
                $display("FAIL R5 miso while deselected: actual %0b expected 0", miso);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [7:0] rx;
        m_cfg = 0; m_ready = 0;
        for (int i = 0; i < 8; i++)  m_ret[i] = 0;
        for (int i = 0; i < 16; i++) m_user[i] = 0;
        rst_n = 0; sclk = 0; ss_n = 1; mosi = 0; ret_load = 0; ret_data = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1", "cfg_out", 128'(cfg_out), 128'(0));
        check("R1", "user_regs", user_regs, 128'(0));
        check("R1", "irq", 128'(irq), 128'(0));
        check("R1", "miso", 128'(miso), 128'(0));

        // R11 user bytes locked while bit5 clear
        txq = '{8'h20, 8'h5A}; run_frame("R11");
        // R3 enable user bytes, then a write burst
        txq = '{8'h00, 8'h20}; run_frame("R3");
        txq = '{8'h20, 8'h11, 8'h22, 8'h33}; run_frame("R3");
        check("R11", "user byte 1 field", 128'(user_regs[15:8]), 128'(8'h22));
        // R4 read burst, unmapped read and wrap to 0x00
        txq = '{8'hA0, 8'h00, 8'h00, 8'h00, 8'h00}; run_frame("R4");
        txq = '{8'hBF, 8'h00, 8'h00}; run_frame("R4");
        txq = '{8'h85, 8'h00}; run_frame("R4");

        // R9 return area, R10 status, R12 interrupt masked
        load_ret(64'hFEDC_BA98_7654_3210);
        txq = '{8'h81, 8'h00}; run_frame("R10");
        txq = '{8'h88, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run_frame("R9");
        txq = '{8'h08, 8'hAA, 8'hBB}; run_frame("R9");
        txq = '{8'h88, 8'h00, 8'h00}; run_frame("R9");
        txq = '{8'h00, 8'h22}; run_frame("R12");
        txq = '{8'h01, 8'h01}; run_frame("R10");
        txq = '{8'h81, 8'h00}; run_frame("R10");

        // R8 remote and reserved commands change nothing
        txq = '{8'hC1, 8'h82, 8'h80, 8'h00, 8'h00}; run_frame("R8");
        txq = '{8'h60, 8'h55, 8'h01}; run_frame("R8");
        txq = '{8'h40, 8'h00}; run_frame("R8");

        // R7 bit order switched inside a frame clears the flag
        load_ret(64'h0123_4567_89AB_CDEF);
        txq = '{8'h00, 8'h32, 8'h01}; run_frame("R7");
        txq = '{8'h21, 8'hC3}; run_frame("R7");
        txq = '{8'hA1, 8'h00}; run_frame("R7");
        txq = '{8'h00, 8'h20}; run_frame("R7");

        // R6 the other three clock modes
        for (int m = 1; m < 4; m++) begin
            txq = '{8'h00, 8'(8'h20 | (m << 2))}; run_frame("R6");
            txq = '{8'h22, 8'(8'h40 + m), 8'(8'h50 + m)}; run_frame("R6");
            txq = '{8'hA2, 8'h00, 8'h00}; run_frame("R6");
        end
        txq = '{8'h00, 8'h20}; run_frame("R6");

        // R2 frame cut in the middle of a data byte
        open_frame();
        xfer_bits(8'h20, 8, rx);
        xfer_bits(8'h99, 4, rx);
        close_frame("R2");
        txq = '{8'h20, 8'h44}; run_frame("R2");

        // R13 disabled slave
        txq = '{8'h00, 8'h21}; run_frame("R13");
        txq = '{8'h20, 8'h77}; run_frame("R13");
        txq = '{8'hA0, 8'h00}; run_frame("R13");
        txq = '{8'h00, 8'h20}; run_frame("R13");
        txq = '{8'hA0, 8'h00}; run_frame("R13");

        finish_up();
    end

endmodule